// File: doc/BRIEF.md
# Two-Lane Interleaving Dispatcher and Collector

This block spreads a stream of packets over two identical compute lanes so that a slow computation can still keep up with a fast input rate. Each packet carries five intensity samples and a base address. A dispatcher registers a packet in every second clock cycle and hands consecutive packets to lane A and lane B in turn. A lane therefore has a four-cycle window for each packet. A collector reads the lane results in the same alternating order and drives one output address bus with a matching valid pulse.

Each lane is treated as an opaque four-cycle unit. Its stand-in function finds the peak sample and moves the base address toward it. The latency from an accepted packet to its result is fixed. Results come out in the order the packets went in, so a consumer can match them to packets by counting.

Top module: `pingpong_lane_pair`

## Requirements
- R1: While `rst` is high at a rising edge, and after that edge, `out_valid` is 0 and `out_addr` is 0. Reset is synchronous and active high, and must be held for at least one rising edge. It sets both the dispatch and collect selectors to lane A.
- R2: Accept slots are the 1st, 3rd, 5th, ... rising edges after `rst` is released. A packet is accepted only when `in_valid` is high at an accept slot. A packet offered in any other cycle is ignored and never produces an output.
- R3: Accepted packets go to lane A and lane B alternately, starting with lane A after reset. The collector takes the results in the same alternating order.
- R4: Each lane holds its packet for exactly four cycles. A lane is never started again before its previous result is produced.
- R5: The result for a packet accepted at rising edge N appears at rising edge N+6. `out_valid` is a single-cycle pulse for each accepted packet.
- R6: The samples are indexed in this order: `in_lo2`=0, `in_lo1`=1, `in_mid`=2, `in_hi1`=3, `in_hi2`=4. `out_addr` = (`in_base` + index of the largest sample − 2) modulo 2^ADDR_W. When several samples are equal and largest, the lowest index wins.
- R7: Packets may be offered at every accept slot. Every packet then yields one result, one every two cycles, in the order the packets were accepted.
- R8: A packet offered at the first rising edge after reset release is accepted.
- R9: A reset that arrives while packets are in flight discards them. None of them produces an output after reset.
- R10: While `out_valid` is low, `out_addr` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Packet offered this cycle |
| in_hi2 | input | DATA_W | Sample two positions above centre |
| in_hi1 | input | DATA_W | Sample one position above centre |
| in_mid | input | DATA_W | Centre sample |
| in_lo1 | input | DATA_W | Sample one position below centre |
| in_lo2 | input | DATA_W | Sample two positions below centre |
| in_base | input | ADDR_W | Address of the centre sample |
| out_valid | output | 1 | Result pulse |
| out_addr | output | ADDR_W | Resulting address |

## Verification
The assertions check the following on every cycle:
- no two accepts happen in consecutive cycles;
- at most one lane starts at a time;
- no lane is restarted while it is busy, and its result pulses are spaced apart;
- the collector takes a lane's result only when it is that lane's turn;
- every output pulse has a matching accept exactly six cycles earlier.

Only the bench scenarios can show the following:
- the value of each address, including ties and wrap at the address limits;
- that packets offered outside an accept slot are dropped;
- that a reset in mid-stream discards work in flight;
- that the stream stays in order at full rate.

// File: rtl/lane_pair_pkg.sv
package lane_pair_pkg;
    parameter int DATA_W      = 8;
    parameter int ADDR_W      = 10;
    parameter int NUM_LANES   = 2;
    parameter int ISSUE_GAP   = 2;
    localparam int LANE_CYCLES = ISSUE_GAP * NUM_LANES;
    localparam int LATENCY     = ISSUE_GAP + LANE_CYCLES;
    localparam int SAMPLES     = 5;
    localparam int CNT_W       = $clog2(LANE_CYCLES + 1);
    localparam int LANE_W      = $clog2(NUM_LANES);

    typedef struct packed {
        logic [DATA_W-1:0] hi2;
        logic [DATA_W-1:0] hi1;
        logic [DATA_W-1:0] mid;
        logic [DATA_W-1:0] lo1;
        logic [DATA_W-1:0] lo2;
        logic [ADDR_W-1:0] base;
    } pkt_t;

    typedef struct packed {
        logic              vld;
        logic [LANE_W-1:0] lane;
        pkt_t              pkt;
    } issue_t;

    // index of the largest sample, lowest index on ties
    function automatic logic [2:0] peak_slot(pkt_t p);
        logic [DATA_W-1:0] s [SAMPLES];
        logic [DATA_W-1:0] best;
        logic [2:0]        idx;
        s[0] = p.lo2;
        s[1] = p.lo1;
        s[2] = p.mid;
        s[3] = p.hi1;
        s[4] = p.hi2;
        best = s[0];
        idx  = 3'd0;
        for (int i = 1; i < SAMPLES; i++) begin
            if (s[i] > best) begin
                best = s[i];
                idx  = 3'(i);
            end
        end
        return idx;
    endfunction

    function automatic logic [ADDR_W-1:0] lane_result(pkt_t p);
        logic [2:0]        off;
        logic [ADDR_W-1:0] off_ext;
        off     = peak_slot(p) - 3'd2;
        off_ext = {{(ADDR_W-3){off[2]}}, off};
        return p.base + off_ext;
    endfunction
endpackage

// File: rtl/lane_dispatch.sv
module lane_dispatch
    import lane_pair_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   in_valid,
    input  pkt_t   in_pkt,
    output issue_t issue
);
    logic              slot_odd;
    logic [LANE_W-1:0] next_lane;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_odd  <= 1'b0;
            next_lane <= '0;
            issue     <= '0;
        end else begin
            slot_odd  <= ~slot_odd;
            issue.vld <= 1'b0;
            if (!slot_odd && in_valid) begin
                issue.vld  <= 1'b1;
                issue.lane <= next_lane;
                issue.pkt  <= in_pkt;
                next_lane  <= next_lane + 1'b1;
            end
        end
    end

    AST_ACCEPT_GAP: assert property (@(posedge clk) disable iff (rst) issue.vld |=> !issue.vld) else $error("accept in consecutive cycles"); // R2
endmodule

// File: rtl/compute_lane.sv
module compute_lane
    import lane_pair_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  pkt_t              pkt,
    output logic              res_valid,
    output logic [ADDR_W-1:0] res_addr
);
    logic [CNT_W-1:0] remain;
    pkt_t             held;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain    <= '0;
            held      <= '0;
            res_valid <= 1'b0;
            res_addr  <= '0;
        end else begin
            res_valid <= 1'b0;
            if (remain == CNT_W'(1)) begin
                res_addr  <= lane_result(held);
                res_valid <= 1'b1;
            end
            if (start) begin
                held   <= pkt;
                remain <= CNT_W'(LANE_CYCLES);
            end else if (remain != '0) begin
                remain <= remain - 1'b1;
            end
        end
    end

    AST_LANE_IDLE: assert property (@(posedge clk) disable iff (rst) start |-> (remain <= CNT_W'(1))) else $error("lane restarted while busy"); // R4
    AST_RESULT_SPACING: assert property (@(posedge clk) disable iff (rst) res_valid |=> !res_valid) else $error("lane result too close"); // R4
endmodule

// File: rtl/result_collect.sv
module result_collect
    import lane_pair_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_LANES-1:0]           res_valid,
    input  logic [NUM_LANES-1:0][ADDR_W-1:0] res_addr,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr
);
    logic [LANE_W-1:0] take;

    always_ff @(posedge clk) begin
        if (rst) begin
            take      <= '0;
            out_valid <= 1'b0;
            out_addr  <= '0;
        end else begin
            out_valid <= 1'b0;
            if (res_valid[take]) begin
                out_valid <= 1'b1;
                out_addr  <= res_addr[take];
                take      <= take + 1'b1;
            end
        end
    end

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_turn
        AST_TAKE_IN_TURN: assert property (@(posedge clk) disable iff (rst) res_valid[g] |-> (take == LANE_W'(g))) else $error("lane result out of turn"); // R3
    end
endmodule

// File: rtl/pingpong_lane_pair.sv
module pingpong_lane_pair
    import lane_pair_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_hi2,
    input  logic [DATA_W-1:0] in_hi1,
    input  logic [DATA_W-1:0] in_mid,
    input  logic [DATA_W-1:0] in_lo1,
    input  logic [DATA_W-1:0] in_lo2,
    input  logic [ADDR_W-1:0] in_base,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr
);
    pkt_t   in_pkt;
    issue_t issue;
    logic [NUM_LANES-1:0]             start;
    logic [NUM_LANES-1:0]             res_valid;
    logic [NUM_LANES-1:0][ADDR_W-1:0] res_addr;

    always_comb begin
        in_pkt.hi2  = in_hi2;
        in_pkt.hi1  = in_hi1;
        in_pkt.mid  = in_mid;
        in_pkt.lo1  = in_lo1;
        in_pkt.lo2  = in_lo2;
        in_pkt.base = in_base;
    end

    lane_dispatch u_dispatch (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_pkt   (in_pkt),
        .issue    (issue)
    );

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        assign start[g] = issue.vld && (issue.lane == LANE_W'(g));
        compute_lane u_lane (
            .clk       (clk),
            .rst       (rst),
            .start     (start[g]),
            .pkt       (issue.pkt),
            .res_valid (res_valid[g]),
            .res_addr  (res_addr[g])
        );
    end

    result_collect u_collect (
        .clk       (clk),
        .rst       (rst),
        .res_valid (res_valid),
        .res_addr  (res_addr),
        .out_valid (out_valid),
        .out_addr  (out_addr)
    );

    AST_SINGLE_START: assert property (@(posedge clk) disable iff (rst) $onehot0(start)) else $error("two lanes started"); // R3
    AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (rst) out_valid |-> $past(issue.vld, LATENCY)) else $error("output without accept"); // R5
endmodule

// File: tb/test_pingpong_lane_pair.sv
module test_pingpong_lane_pair;
    import lane_pair_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic [DATA_W-1:0] in_hi2 = '0, in_hi1 = '0, in_mid = '0, in_lo1 = '0, in_lo2 = '0;
    logic [ADDR_W-1:0] in_base = '0;
    logic              out_valid;
    logic [ADDR_W-1:0] out_addr;

    pingpong_lane_pair i_pingpong_lane_pair (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .in_hi2(in_hi2), .in_hi1(in_hi1), .in_mid(in_mid),
        .in_lo1(in_lo1), .in_lo2(in_lo2), .in_base(in_base),
        .out_valid(out_valid), .out_addr(out_addr)
    );

    always #5 clk = ~clk;

    typedef struct {
        int                due;
        logic [ADDR_W-1:0] addr;
    } exp_t;

    exp_t              sb[$];
    int                checks = 0;
    int                fails  = 0;
    int                cyc    = 0;
    int                rel    = 0;
    logic [ADDR_W-1:0] last_addr = '0;
    bit                done = 1'b0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst) rel <= 0;
        else     rel <= rel + 1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    function automatic logic [ADDR_W-1:0] model(input int s0, input int s1, input int s2,
                                                input int s3, input int s4, input int base);
        int v[5];
        int best;
        int at;
        v[0] = s0; v[1] = s1; v[2] = s2; v[3] = s3; v[4] = s4;
        best = v[0];
        at   = 0;
        for (int i = 1; i < 5; i++) if (v[i] > best) begin best = v[i]; at = i; end
        return ADDR_W'(base + at - 2);
    endfunction

    // drive one packet in the next accept slot (or next off slot if odd)
    task automatic offer(input int lo2, input int lo1, input int mid, input int hi1,
                         input int hi2, input int base, input bit odd_slot);
        @(negedge clk);
        while ((rel % 2 == 0) == odd_slot) @(negedge clk);
        in_valid = 1'b1;
        in_lo2 = DATA_W'(lo2); in_lo1 = DATA_W'(lo1); in_mid = DATA_W'(mid);
        in_hi1 = DATA_W'(hi1); in_hi2 = DATA_W'(hi2); in_base = ADDR_W'(base);
        if (!odd_slot) sb.push_back('{cyc + 7, model(lo2, lo1, mid, hi1, hi2, base)});
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst) begin
            check(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
            last_addr = '0;
        end else if (out_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R2/R9 unexpected output", int'(out_addr), -1);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(cyc == e.due, "R5 latency", cyc, e.due);
                check(out_addr == e.addr, "R6/R7 address", int'(out_addr), int'(e.addr));
            end
            last_addr = out_addr;
        end else begin
            check(out_addr == last_addr, "R10 hold", int'(out_addr), int'(last_addr));
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(out_addr == '0, "R1 out_addr in reset", int'(out_addr), 0);
        rst = 1'b0;
        // R8: packet at the very first slot after release
        in_valid = 1'b1;
        in_lo2 = 8'd1; in_lo1 = 8'd2; in_mid = 8'd3; in_hi1 = 8'd9; in_hi2 = 8'd4; in_base = 10'd100;
        sb.push_back('{cyc + 7, model(1, 2, 3, 9, 4, 100)});
        @(posedge clk);
        #1 in_valid = 1'b0;
        idle(10);
        check(sb.size() == 0, "R8 first packet drained", sb.size(), 0);

        // R6: peak at each index, ties, wrap at both ends
        offer(50, 1, 1, 1, 1, 200, 0);
        offer(1, 50, 1, 1, 1, 200, 0);
        offer(1, 1, 50, 1, 1, 200, 0);
        offer(1, 1, 1, 50, 1, 200, 0);
        offer(1, 1, 1, 1, 50, 200, 0);
        offer(7, 7, 7, 7, 7, 300, 0);
        offer(0, 9, 3, 9, 0, 300, 0);
        offer(200, 1, 1, 1, 1, 0, 0);
        offer(1, 1, 1, 1, 255, 1023, 0);
        offer(1, 1, 1, 255, 255, 1022, 0);
        idle(10);

        // R2: packets only in off slots are ignored
        offer(1, 1, 1, 1, 99, 500, 1);
        offer(99, 1, 1, 1, 1, 600, 1);
        idle(10);
        check(sb.size() == 0, "R2 no pending", sb.size(), 0);

        // R7 and R3: full-rate stream with varied data
        for (int k = 0; k < 24; k++)
            offer((k * 37) % 256, (k * 53) % 256, (k * 11) % 256, (k * 71) % 256,
                  (k * 29) % 256, (k * 97) % 1024, 0);
        // mixed gaps
        for (int k = 0; k < 8; k++) begin
            offer(k, 2 * k, 3, 40 - k, k * k, 50 + k, 0);
            idle(k % 3);
        end
        idle(12);
        check(sb.size() == 0, "R7 stream drained", sb.size(), 0);

        // R9: reset in mid-flight discards work
        offer(1, 90, 1, 1, 1, 700, 0);
        offer(1, 1, 1, 90, 1, 710, 0);
        idle(2);
        rst = 1'b1;
        sb.delete();
        idle(2);
        rst = 1'b0;
        idle(12);
        check(sb.size() == 0, "R9 nothing pending", sb.size(), 0);

        // after reset both selectors back at lane A (R1, R3)
        offer(5, 1, 1, 1, 1, 800, 0);
        offer(1, 1, 1, 1, 5, 810, 0);
        offer(1, 1, 5, 1, 1, 820, 0);
        idle(12);
        check(sb.size() == 0, "R3 post-reset drained", sb.size(), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule